// File: doc/BRIEF.md
# NAND Flash Chunk ECC Checker

This block takes two 24-bit check codes for one 256-byte chunk of flash data: the code read back from the spare area, and the code recomputed over the data as it was read. It XORs the 22 meaningful parity bits of the two codes to form a syndrome. From the syndrome it decides whether the chunk is clean, holds one flipped data bit that can be repaired, has a single flipped bit inside the stored code, or has an error it cannot repair.

The code is built from sixteen line-parity bits and six column-parity bits. These form eleven complementary even/odd pairs. When exactly one data bit has flipped, every pair in the syndrome differs. The odd member of each pair then spells out the failing byte offset and the bit index inside that byte. The block reports that location. Flipping the bit in the buffered data is left to the surrounding logic.

A one-cycle start strobe loads the decision into output registers, and a done pulse follows one cycle later. The registered result stays unchanged until the next strobe.

Top module: `ecc_chk_top`

## Requirements
- R1: A code is packed as bits 7:0 = line parity LP7..LP0, bits 15:8 = LP15..LP8, bits 23:18 = column parity CP5..CP0, and bits 17:16 = two pad bits. The syndrome is the XOR of the 22 parity bits of the two codes. A difference in the pad bits has no effect on any output.
- R2: An all-zero syndrome gives status 0 (clean).
- R3: The syndrome may have exactly one bit set in each pair (LP2k/LP2k+1 for k=0..7, CP2k/CP2k+1 for k=0..2). Then status is 1 (data fix), and a single flipped data bit is reported. err_byte is {LP15,LP13,LP11,LP9,LP7,LP5,LP3,LP1} of the syndrome, MSB first. err_bit is {CP5,CP3,CP1}.
- R4: A syndrome with exactly one bit set gives status 2 (stored code error).
- R5: Every other syndrome gives status 3 (uncorrectable). This includes any two flipped data bits and any two flipped code bits.
- R6: done is high in the cycle after a cycle in which start was high, and low otherwise. The outputs show the result for the codes that were present with start.
- R7: Without start, status, err_byte and err_bit hold their values.
- R8: While rst is high, the block clears status, err_byte, err_bit and done to 0 at each clock edge.
- R9: err_byte and err_bit are 0 whenever status is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Evaluate the two codes this cycle |
| code_stored | input | 24 | Check code read back from flash |
| code_calc | input | 24 | Check code recomputed over the read data |
| status | output | 2 | 0 clean, 1 data fix, 2 stored code error, 3 uncorrectable |
| err_byte | output | 8 | Offset of the failing byte within the chunk |
| err_bit | output | 3 | Index of the failing bit within that byte |
| done | output | 1 | Result valid pulse, one cycle after start |

## Verification
On every cycle the assertions check the following:
- done is tied to the previous cycle's strobe.
- Results hold while there is no strobe.
- Equal codes always yield clean status.
- A single differing parity bit always yields a stored code error.
- The location outputs are zero outside the data-fix status.

Only the bench scenarios can show that the decoded byte offset and bit index match the bit that was really flipped. The bench builds codes from a real 256-byte chunk, flips a chosen bit, and compares against the known position. The same approach shows that two-bit damage is classed as uncorrectable and that the pad bits are ignored.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;

    localparam int LP_BITS = 16;
    localparam int CP_BITS = 6;
    localparam int CODE_W  = 24;
    localparam int SYN_W   = LP_BITS + CP_BITS;
    localparam int PAIRS   = SYN_W / 2;
    localparam int ADDR_W  = LP_BITS / 2;
    localparam int IDX_W   = CP_BITS / 2;
    localparam int PAD_W   = CODE_W - SYN_W;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_DATA_FIX = 2'd1,
        ST_CODE_ERR = 2'd2,
        ST_FATAL    = 2'd3
    } ecc_status_e;

    typedef struct packed {
        logic [CP_BITS-1:0] cp;
        logic [LP_BITS-1:0] lp;
    } parity_t;

    typedef struct packed {
        ecc_status_e        status;
        logic [ADDR_W-1:0]  byte_addr;
        logic [IDX_W-1:0]   bit_idx;
    } verdict_t;

    // Strip the pad bits and keep the 22 parity bits of a packed code.
    function automatic parity_t unpack_code(input logic [CODE_W-1:0] c);
        parity_t p;
        p.lp = c[LP_BITS-1:0];
        p.cp = c[CODE_W-1 -: CP_BITS];
        return p;
    endfunction

    // Mask selecting the meaningful parity bits of a packed code.
    function automatic logic [CODE_W-1:0] parity_mask();
        return {{CP_BITS{1'b1}}, {PAD_W{1'b0}}, {LP_BITS{1'b1}}};
    endfunction

endpackage

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
    import ecc_chk_pkg::*;
(
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    output parity_t           syn
);
    parity_t pa, pb;

    always_comb begin
        pa  = unpack_code(code_a);
        pb  = unpack_code(code_b);
        syn = pa ^ pb;
    end
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
    import ecc_chk_pkg::*;
(
    input  parity_t     syn,
    output ecc_status_e status
);
    logic [SYN_W-1:0] flat;
    logic [PAIRS-1:0] pair_diff;

    assign flat = syn;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        assign pair_diff[k] = flat[2*k] ^ flat[2*k+1];
    end

    always_comb begin
        if (flat == '0)
            status = ST_CLEAN;
        else if (&pair_diff)
            status = ST_DATA_FIX;
        else if ($onehot(flat))
            status = ST_CODE_ERR;
        else
            status = ST_FATAL;
    end
endmodule

// File: rtl/ecc_locate.sv
module ecc_locate
    import ecc_chk_pkg::*;
(
    input  parity_t           syn,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [IDX_W-1:0]  bit_idx
);
    for (genvar k = 0; k < ADDR_W; k++) begin : g_addr
        assign byte_addr[k] = syn.lp[2*k+1];
    end

    for (genvar k = 0; k < IDX_W; k++) begin : g_idx
        assign bit_idx[k] = syn.cp[2*k+1];
    end
endmodule

// File: rtl/ecc_chk_top.sv
module ecc_chk_top
    import ecc_chk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [CODE_W-1:0]  code_stored,
    input  logic [CODE_W-1:0]  code_calc,
    output logic [1:0]         status,
    output logic [ADDR_W-1:0]  err_byte,
    output logic [IDX_W-1:0]   err_bit,
    output logic               done
);
    parity_t           syn;
    ecc_status_e       cls;
    logic [ADDR_W-1:0] loc_byte;
    logic [IDX_W-1:0]  loc_bit;
    verdict_t          nxt;
    verdict_t          res_q;
    logic              done_q;

    ecc_syndrome u_syn (
        .code_a (code_stored),
        .code_b (code_calc),
        .syn    (syn)
    );

    ecc_classify u_cls (
        .syn    (syn),
        .status (cls)
    );

    ecc_locate u_loc (
        .syn       (syn),
        .byte_addr (loc_byte),
        .bit_idx   (loc_bit)
    );

    always_comb begin
        nxt.status    = cls;
        nxt.byte_addr = (cls == ST_DATA_FIX) ? loc_byte : '0;
        nxt.bit_idx   = (cls == ST_DATA_FIX) ? loc_bit  : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= start;
            if (start)
                res_q <= nxt;
        end
    end

    assign status   = res_q.status;
    assign err_byte = res_q.byte_addr;
    assign err_bit  = res_q.bit_idx;
    assign done     = done_q;
endmodule

// File: rtl/ecc_chk_sva.sv
module ecc_chk_sva
    import ecc_chk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [CODE_W-1:0] code_stored,
    input logic [CODE_W-1:0] code_calc,
    input logic [1:0]        status,
    input logic [ADDR_W-1:0] err_byte,
    input logic [IDX_W-1:0]  err_bit,
    input logic              done
);
    logic [CODE_W-1:0] diff;
    assign diff = (code_stored ^ code_calc) & parity_mask();

    a_r6_done_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    a_r6_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    a_r2_equal_is_clean: assert property (@(posedge clk) disable iff (rst)
        (start && diff == '0) |=> status == 2'd0);

    a_r4_single_diff_code_err: assert property (@(posedge clk) disable iff (rst)
        (start && $countones(diff) == 1) |=> status == 2'd2);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(status) && $stable(err_byte) && $stable(err_bit)));

    a_r9_loc_zero: assert property (@(posedge clk) disable iff (rst)
        (status != 2'd1) |-> (err_byte == '0 && err_bit == '0));

    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (status == 2'd0 && err_byte == '0 && err_bit == '0 && !done));
endmodule

bind ecc_chk_top ecc_chk_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .code_stored (code_stored),
    .code_calc   (code_calc),
    .status      (status),
    .err_byte    (err_byte),
    .err_bit     (err_bit),
    .done        (done)
);

// File: tb/ecc_chk_top_tb.sv
module ecc_chk_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] code_stored = '0;
    logic [23:0] code_calc = '0;
    logic [1:0]  status;
    logic [7:0]  err_byte;
    logic [2:0]  err_bit;
    logic        done;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string cur_req = "R8";

    logic [7:0] mem [256];

    // reference model state
    logic [1:0] m_status = 2'd0;
    logic [7:0] m_byte = '0;
    logic [2:0] m_bit = '0;
    logic       m_done = 1'b0;

    always #5 clk = ~clk;

    ecc_chk_top u_dut (
        .clk(clk), .rst(rst), .start(start),
        .code_stored(code_stored), .code_calc(code_calc),
        .status(status), .err_byte(err_byte), .err_bit(err_bit), .done(done)
    );

    // Behavioural code generator over the 256-byte chunk in mem.
    function automatic logic [23:0] gen_ecc();
        logic [15:0] lp = '0;
        logic [5:0]  cp = '0;
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (mem[i][j]) begin
                    for (int k = 0; k < 8; k++) begin
                        if (i[k]) lp[2*k+1] = ~lp[2*k+1];
                        else      lp[2*k]   = ~lp[2*k];
                    end
                    for (int k = 0; k < 3; k++) begin
                        if (j[k]) cp[2*k+1] = ~cp[2*k+1];
                        else      cp[2*k]   = ~cp[2*k];
                    end
                end
            end
        end
        return {cp, 2'b11, lp};
    endfunction

    // Reference decision, written from the requirements.
    task automatic ref_decide(input logic [23:0] a, input logic [23:0] b,
                              output logic [1:0] st, output logic [7:0] by,
                              output logic [2:0] bi);
        logic [21:0] s;
        int  ones;
        bit  all_pairs;
        s = {a[23:18] ^ b[23:18], a[15:0] ^ b[15:0]};
        ones = 0;
        all_pairs = 1;
        for (int i = 0; i < 22; i++) ones += s[i];
        for (int p = 0; p < 11; p++) if (s[2*p] == s[2*p+1]) all_pairs = 0;
        by = '0;
        bi = '0;
        if (ones == 0) st = 2'd0;
        else if (all_pairs) begin
            st = 2'd1;
            for (int k = 0; k < 8; k++) by[k] = s[2*k+1];
            for (int k = 0; k < 3; k++) bi[k] = s[16+2*k+1];
        end
        else if (ones == 1) st = 2'd2;
        else st = 2'd3;
    endtask

    always @(posedge clk) begin
        logic [1:0] st;
        logic [7:0] by;
        logic [2:0] bi;
        if (rst) begin
            m_status <= 2'd0; m_byte <= '0; m_bit <= '0; m_done <= 1'b0;
        end else begin
            m_done <= start;
            if (start) begin
                ref_decide(code_stored, code_calc, st, by, bi);
                m_status <= st; m_byte <= by; m_bit <= bi;
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        vectors++;
        if (status !== m_status || err_byte !== m_byte || err_bit !== m_bit || done !== m_done) begin
            miscompares++;
            $display("FAIL %s model: got st=%0d byte=%0d bit=%0d done=%0b exp st=%0d byte=%0d bit=%0d done=%0b",
                     cur_req, status, err_byte, err_bit, done, m_status, m_byte, m_bit, m_done);
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            miscompares++;
            $display("FAIL watchdog: got timeout exp completion");
            finish_run();
        end
    end

    task automatic apply(input logic [23:0] s, input logic [23:0] c);
        @(negedge clk);
        code_stored = s; code_calc = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // explicit check with independently known expected values
    task automatic expect_out(input string req, input logic [1:0] st,
                              input logic [7:0] by, input logic [2:0] bi,
                              input logic dn);
        vectors++;
        if (status !== st || err_byte !== by || err_bit !== bi || done !== dn) begin
            miscompares++;
            $display("FAIL %s: got st=%0d byte=%0d bit=%0d done=%0b exp st=%0d byte=%0d bit=%0d done=%0b",
                     req, status, err_byte, err_bit, done, st, by, bi, dn);
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    endtask

    task automatic data_flip(input int b, input int bt);
        logic [23:0] good;
        logic [23:0] bad;
        good = gen_ecc();
        mem[b][bt] = ~mem[b][bt];
        bad = gen_ecc();
        mem[b][bt] = ~mem[b][bt];
        apply(good, bad);
        expect_out("R3", 2'd1, 8'(b), 3'(bt), 1'b1);
    endtask

    initial begin
        logic [23:0] g;
        logic [23:0] b2;
        fill_random();
        repeat (3) @(negedge clk);
        cur_req = "R8";
        expect_out("R8", 2'd0, 8'd0, 3'd0, 1'b0);
        rst = 1'b0;

        // R2: identical codes
        cur_req = "R2";
        g = gen_ecc();
        apply(g, g);
        expect_out("R2", 2'd0, 8'd0, 3'd0, 1'b1);
        @(negedge clk);
        expect_out("R6", 2'd0, 8'd0, 3'd0, 1'b0);

        // R3: single data bit flips including corners
        cur_req = "R3";
        data_flip(0, 0);
        data_flip(255, 7);
        data_flip(165, 6);
        data_flip(90, 1);
        for (int n = 0; n < 20; n++) data_flip(int'($urandom_range(255)), int'($urandom_range(7)));

        // R4: each meaningful code bit flipped in the stored copy
        cur_req = "R4";
        g = gen_ecc();
        for (int p = 0; p < 24; p++) begin
            if (p == 16 || p == 17) continue;
            apply(g ^ (24'd1 << p), g);
            expect_out("R4", 2'd2, 8'd0, 3'd0, 1'b1);
        end

        // R1: pad bits ignored, alone and with a data error
        cur_req = "R1";
        apply(g ^ 24'h030000, g);
        expect_out("R1", 2'd0, 8'd0, 3'd0, 1'b1);
        mem[7][3] = ~mem[7][3];
        b2 = gen_ecc();
        mem[7][3] = ~mem[7][3];
        apply(g ^ 24'h010000, b2);
        expect_out("R1", 2'd1, 8'd7, 3'd3, 1'b1);

        // R5: two data bit flips, two code bit flips
        cur_req = "R5";
        for (int n = 0; n < 10; n++) begin
            int a1, a2, t1, t2;
            a1 = int'($urandom_range(255)); t1 = int'($urandom_range(7));
            a2 = (a1 + 1 + int'($urandom_range(254))) % 256; t2 = int'($urandom_range(7));
            mem[a1][t1] = ~mem[a1][t1]; mem[a2][t2] = ~mem[a2][t2];
            b2 = gen_ecc();
            mem[a1][t1] = ~mem[a1][t1]; mem[a2][t2] = ~mem[a2][t2];
            apply(g, b2);
            expect_out("R5", 2'd3, 8'd0, 3'd0, 1'b1);
        end
        mem[10][2] = ~mem[10][2]; mem[10][5] = ~mem[10][5];
        b2 = gen_ecc();
        mem[10][2] = ~mem[10][2]; mem[10][5] = ~mem[10][5];
        apply(g, b2);
        expect_out("R5", 2'd3, 8'd0, 3'd0, 1'b1);
        apply(g ^ 24'h000003, g);
        expect_out("R5", 2'd3, 8'd0, 3'd0, 1'b1);
        apply(g ^ 24'h840000, g);
        expect_out("R9", 2'd3, 8'd0, 3'd0, 1'b1);

        // R7: load a fix result, then change inputs without start
        cur_req = "R7";
        data_flip(200, 4);
        code_stored = 24'h123456; code_calc = 24'hFEDCBA;
        repeat (4) @(negedge clk);
        expect_out("R7", 2'd1, 8'd200, 3'd4, 1'b0);

        // R6: back-to-back strobes
        cur_req = "R6";
        @(negedge clk);
        code_stored = g; code_calc = g; start = 1'b1;
        @(negedge clk);
        expect_out("R6", 2'd0, 8'd0, 3'd0, 1'b1);
        code_stored = g ^ 24'h000100;
        @(negedge clk);
        start = 1'b0;
        expect_out("R6", 2'd2, 8'd0, 3'd0, 1'b1);

        // R8: reset clears a loaded result
        cur_req = "R8";
        data_flip(33, 2);
        rst = 1'b1;
        @(negedge clk);
        expect_out("R8", 2'd0, 8'd0, 3'd0, 1'b0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule